// File: doc/BRIEF.md
# Two-Level Virtual Address Translation Walker

This block turns a 32-bit virtual address into a 34-bit physical address by reading a two-level page table from memory, one 32-bit entry at a time. It is placed behind a translation cache. On a miss, the cache hands the walker one request. The request carries the access kind, the current privilege, the user-page access override (SUM), the executable-readable override (MXR), the modify-privilege control (MPRV) with its saved privilege (MPP), and the translation mode and root page number. The walker returns one response pulse with the physical address, the read, write and execute rights to cache, and a fault flag.

During the walk the block applies every leaf rule: reserved encodings, user and supervisor page ownership, superpage alignment and rights per access kind. If an entry's accessed bit is clear, or a store finds its dirty bit clear, the block writes the updated entry back to the same memory word before it responds. In bare mode, or when the effective privilege is machine, no memory is read and the address passes through unchanged.

Top module: `sv32_walker`

## Requirements
- R1: With `xlat_mode`=0 (bare), an accepted request gives `resp_valid` in the very next cycle, with `resp_paddr` equal to the zero-extended virtual address, all three rights set, no fault and no memory access.
- R2: Privilege encoding is 0=user, 1=supervisor, 3=machine. Access kind encoding is 0=fetch, 1=load, 2=store. The effective privilege is `req_mpp` when the privilege is machine, `req_mprv`=1 and the kind is not fetch; otherwise it is `req_priv`. An effective privilege of machine passes the address through as in R1.
- R3: Entry layout: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, page number bits 31:10. The first read is at root×4096 + VA[31:22]×4. A pointer leads to a second read at its page number×4096 + VA[21:12]×4.
- R4: The walk faults on an entry with V=0, on a pointer (R=W=X=0) found at the second level, or on a transfer completed with `mem_err`=1.
- R5: A leaf with W=1 and R=0 (W-only or W+X) faults.
- R6: A user page (U=1) faults for a non-user privilege unless SUM=1, and always faults for a fetch from such a privilege. A non-user page faults unless the privilege is supervisor.
- R7: A leaf found at the first level with entry bits 19:10 nonzero faults.
- R8: A load needs R, or X with MXR=1. A store needs W. A fetch needs X. Otherwise the walk faults.
- R9: If A=0, or the access is a store with D=0, the walker writes the entry back to the same address with A set (and D set for a store) before responding. Otherwise it writes nothing.
- R10: The physical address is {entry[31:10], VA[11:0]} for a second-level leaf and {entry[31:20], VA[21:0]} for a first-level leaf.
- R11: Reported read right is R or (X and MXR). Reported execute right is X. Reported write right is W and (store or D). A fault response has address 0 and no rights.
- R12: `req_ready` is high only while idle. `resp_valid` lasts one cycle. A memory request keeps `mem_valid`, `mem_addr` and `mem_write` stable until `mem_ready`, and read data and `mem_err` are taken in the cycle where `mem_valid` and `mem_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege, 0 user, 1 supervisor, 3 machine |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Executable pages are readable |
| req_mprv | input | 1 | Data accesses in machine mode use req_mpp |
| req_mpp | input | 2 | Saved privilege used under req_mprv |
| xlat_mode | input | 1 | 0 bare, 1 two-level paging |
| xlat_root | input | 22 | Root table page number |
| mem_valid | output | 1 | Memory transfer requested |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_write | output | 1 | 1 write-back, 0 entry read |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry |
| mem_rdata | input | 32 | Entry read data |
| mem_err | input | 1 | Transfer error |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | 34 | Physical address |
| resp_r | output | 1 | Read right |
| resp_w | output | 1 | Write right |
| resp_x | output | 1 | Execute right |
| resp_fault | output | 1 | Translation failed |

## Verification
A pass-through result is due one cycle after the accepting edge. A paged result is due one cycle after the final memory transfer completes: one or two reads, plus one write-back when required. Each stall cycle on `mem_ready` pushes the result back by one cycle. The bench drives inputs and the memory model on falling edges, and then waits on falling edges for `resp_valid`. It counts the cycles it waits and checks them against these expected totals: exactly one cycle for bare mode, and three plus the inserted stalls for a two-read walk. It also logs every entry address and write-back, so the number and location of memory transfers per walk are checked as well as the result.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 34;
    localparam int ENTRY_W  = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int PPN_W    = PA_W - OFF_W;
    localparam int PPN_HI_W = PPN_W - IDX_W;
    localparam int PPN_LSB  = 10;

    localparam int B_V  = 0;
    localparam int B_R  = 1;
    localparam int B_WR = 2;
    localparam int B_X  = 3;
    localparam int B_U  = 4;
    localparam int B_A  = 6;
    localparam int B_D  = 7;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_SUPER = 2'd1;
    localparam logic [1:0] LVL_MACH  = 2'd3;

    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE, PH_DONE} phase_e;

    typedef struct packed {
        phase_e               phase;
        logic                 top;
        logic [PPN_W-1:0]     base;
        logic [VA_W-1:0]      vaddr;
        logic [1:0]           kind;
        logic [1:0]           priv;
        logic                 sum;
        logic                 mxr;
        logic [ENTRY_W-1:0]   wpte;
        logic [PA_W-1:0]      paddr;
        logic [2:0]           rwx;
        logic                 fault;
    } walk_st_t;
endpackage

// File: rtl/sv32_priv_resolve.sv
module sv32_priv_resolve
    import sv32_walk_pkg::*;
(
    input  logic [1:0] priv,
    input  logic [1:0] kind,
    input  logic       mprv,
    input  logic [1:0] mpp,
    output logic [1:0] eff_priv
);
    always_comb begin
        if (priv == LVL_MACH && kind != ACC_FETCH && mprv)
            eff_priv = mpp;
        else
            eff_priv = priv;
    end
endmodule

// File: rtl/sv32_leaf_check.sv
module sv32_leaf_check
    import sv32_walk_pkg::*;
(
    input  logic [ENTRY_W-1:0] pte,
    input  logic               top,
    input  logic [1:0]         kind,
    input  logic [1:0]         priv,
    input  logic               sum,
    input  logic               mxr,
    output logic               leaf_ok,
    output logic [2:0]         rwx,
    output logic               wb_need,
    output logic [ENTRY_W-1:0] wb_pte
);
    logic r, w, x, u, a, d, store;
    logic reserved, u_bad, s_bad, misaligned, perm_bad;

    always_comb begin
        r     = pte[B_R];
        w     = pte[B_WR];
        x     = pte[B_X];
        u     = pte[B_U];
        a     = pte[B_A];
        d     = pte[B_D];
        store = (kind == ACC_STORE);

        reserved   = w && !r;
        u_bad      = u && (priv != LVL_USER) && (!sum || kind == ACC_FETCH);
        s_bad      = !u && (priv != LVL_SUPER);
        misaligned = top && (pte[PPN_LSB +: IDX_W] != '0);
        case (kind)
            ACC_LOAD:  perm_bad = !(r || (x && mxr));
            ACC_STORE: perm_bad = !w;
            default:   perm_bad = !x;
        endcase
        leaf_ok = !(reserved || u_bad || s_bad || misaligned || perm_bad);

        rwx     = {r || (x && mxr), w && (store || d), x};
        wb_need = !a || (store && !d);
        wb_pte  = pte;
        wb_pte[B_A] = 1'b1;
        if (store) wb_pte[B_D] = 1'b1;
    end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
    import sv32_walk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [1:0]           req_kind,
    input  logic [1:0]           req_priv,
    input  logic                 req_sum,
    input  logic                 req_mxr,
    input  logic                 req_mprv,
    input  logic [1:0]           req_mpp,
    input  logic                 xlat_mode,
    input  logic [PPN_W-1:0]     xlat_root,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic                 mem_write,
    output logic [PA_W-1:0]      mem_addr,
    output logic [ENTRY_W-1:0]   mem_wdata,
    input  logic [ENTRY_W-1:0]   mem_rdata,
    input  logic                 mem_err,
    output logic                 resp_valid,
    output logic [PA_W-1:0]      resp_paddr,
    output logic                 resp_r,
    output logic                 resp_w,
    output logic                 resp_x,
    output logic                 resp_fault
);
    walk_st_t st_q, st_d;

    logic [1:0]         eff_priv;
    logic               leaf_ok, wb_need;
    logic [2:0]         leaf_rwx;
    logic [ENTRY_W-1:0] wb_pte;
    logic [IDX_W-1:0]   vpn_sel;
    logic [PA_W-1:0]    leaf_paddr;

    sv32_priv_resolve u_priv (
        .priv     (req_priv),
        .kind     (req_kind),
        .mprv     (req_mprv),
        .mpp      (req_mpp),
        .eff_priv (eff_priv)
    );

    sv32_leaf_check u_leaf (
        .pte     (mem_rdata),
        .top     (st_q.top),
        .kind    (st_q.kind),
        .priv    (st_q.priv),
        .sum     (st_q.sum),
        .mxr     (st_q.mxr),
        .leaf_ok (leaf_ok),
        .rwx     (leaf_rwx),
        .wb_need (wb_need),
        .wb_pte  (wb_pte)
    );

    always_comb begin
        vpn_sel = st_q.top ? st_q.vaddr[VA_W-1 -: IDX_W] : st_q.vaddr[OFF_W +: IDX_W];
        if (st_q.top)
            leaf_paddr = {mem_rdata[ENTRY_W-1 -: PPN_HI_W], st_q.vaddr[OFF_W +: IDX_W],
                          st_q.vaddr[OFF_W-1:0]};
        else
            leaf_paddr = {mem_rdata[PPN_LSB +: PPN_W], st_q.vaddr[OFF_W-1:0]};
    end

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.fault = 1'b0;
                    if (!xlat_mode || eff_priv == LVL_MACH) begin
                        st_d.phase = PH_DONE;
                        st_d.paddr = {{(PA_W-VA_W){1'b0}}, req_vaddr};
                        st_d.rwx   = 3'b111;
                    end else begin
                        st_d.phase = PH_READ;
                        st_d.top   = 1'b1;
                        st_d.base  = xlat_root;
                        st_d.vaddr = req_vaddr;
                        st_d.kind  = req_kind;
                        st_d.priv  = eff_priv;
                        st_d.sum   = req_sum;
                        st_d.mxr   = req_mxr;
                        st_d.paddr = '0;
                        st_d.rwx   = '0;
                    end
                end
            end
            PH_READ: begin
                if (mem_ready) begin
                    if (mem_err || !mem_rdata[B_V]) begin
                        st_d.phase = PH_DONE;
                        st_d.fault = 1'b1;
                    end else if (!mem_rdata[B_R] && !mem_rdata[B_WR] && !mem_rdata[B_X]) begin
                        if (st_q.top) begin
                            st_d.top  = 1'b0;
                            st_d.base = mem_rdata[PPN_LSB +: PPN_W];
                        end else begin
                            st_d.phase = PH_DONE;
                            st_d.fault = 1'b1;
                        end
                    end else if (!leaf_ok) begin
                        st_d.phase = PH_DONE;
                        st_d.fault = 1'b1;
                    end else begin
                        st_d.paddr = leaf_paddr;
                        st_d.rwx   = leaf_rwx;
                        st_d.wpte  = wb_pte;
                        st_d.phase = wb_need ? PH_WRITE : PH_DONE;
                    end
                end
            end
            PH_WRITE: begin
                if (mem_ready) begin
                    st_d.phase = PH_DONE;
                    if (mem_err) begin
                        st_d.fault = 1'b1;
                        st_d.paddr = '0;
                        st_d.rwx   = '0;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == PH_IDLE);
    assign mem_valid  = (st_q.phase == PH_READ) || (st_q.phase == PH_WRITE);
    assign mem_write  = (st_q.phase == PH_WRITE);
    assign mem_addr   = {st_q.base, vpn_sel, 2'b00};
    assign mem_wdata  = st_q.wpte;
    assign resp_valid = (st_q.phase == PH_DONE);
    assign resp_paddr = st_q.paddr;
    assign resp_r     = st_q.rwx[2];
    assign resp_w     = st_q.rwx[1];
    assign resp_x     = st_q.rwx[0];
    assign resp_fault = st_q.fault;

    assert_bare_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_mode)
        |=> (resp_valid && !resp_fault && resp_r && resp_w && resp_x));

    assert_mach_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_priv == LVL_MACH
         && !(req_mprv && req_kind != ACC_FETCH))
        |=> (resp_valid && !resp_fault && !mem_valid));

    assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> (mem_wdata[B_A] && mem_wdata[B_V]));

    assert_fault_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (!resp_r && !resp_w && !resp_x && resp_paddr == '0));

    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));
endmodule

// File: tb/sv32_walker_bench.sv
module sv32_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam logic [1:0] K_F = 2'd0, K_L = 2'd1, K_S = 2'd2;
    localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;
    localparam logic [33:0] ERR_ADDR = 34'h000002020;

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic [1:0]  priv;
        logic        sum;
        logic        mxr;
        logic        mprv;
        logic [1:0]  mpp;
        logic        mode;
        logic [33:0] pa;
        logic [2:0]  rwx;
        logic        flt;
        logic [1:0]  nwr;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{32'hDEADBEEF, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b0, 34'h0DEADBEEF, 3'b111, 1'b0, 2'd0, 8'd1},  // R1
        '{32'h12345678, K_L, P_M, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h012345678, 3'b111, 1'b0, 2'd0, 8'd2},  // R2
        '{32'h00457ABC, K_L, P_M, 1'b0, 1'b0, 1'b1, P_S, 1'b1, 34'h048C57ABC, 3'b111, 1'b0, 2'd0, 8'd2},  // R2 MPRV
        '{32'h00457ABC, K_F, P_M, 1'b0, 1'b0, 1'b1, P_S, 1'b1, 34'h000457ABC, 3'b111, 1'b0, 2'd0, 8'd2},  // R2 fetch
        '{32'h00457ABC, K_F, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h048C57ABC, 3'b111, 1'b0, 2'd0, 8'd10}, // R10
        '{32'h00800000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd7},  // R7
        '{32'h00C00000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd4},  // R4
        '{32'h00000123, K_L, P_U, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h00ABCD123, 3'b111, 1'b0, 2'd0, 8'd10}, // R10
        '{32'h00000123, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd6},  // R6
        '{32'h00000123, K_L, P_S, 1'b1, 1'b0, 1'b0, P_U, 1'b1, 34'h00ABCD123, 3'b111, 1'b0, 2'd0, 8'd6},  // R6
        '{32'h00000123, K_F, P_S, 1'b1, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd6},  // R6
        '{32'h00002010, K_L, P_U, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd6},  // R6
        '{32'h00002010, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h022222010, 3'b100, 1'b0, 2'd0, 8'd11}, // R11
        '{32'h00002010, K_S, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h022222010, 3'b110, 1'b0, 2'd1, 8'd9},  // R9
        '{32'h00003000, K_S, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd5},  // R5
        '{32'h00004000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd5},  // R5
        '{32'h00005000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd8},  // R8
        '{32'h00005000, K_L, P_S, 1'b0, 1'b1, 1'b0, P_U, 1'b1, 34'h055555000, 3'b101, 1'b0, 2'd0, 8'd8},  // R8
        '{32'h00005000, K_S, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd8},  // R8
        '{32'h00006000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd4},  // R4
        '{32'h00007000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd4},  // R4
        '{32'h00008000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h0,         3'b000, 1'b1, 2'd0, 8'd4},  // R4
        '{32'h00001000, K_L, P_S, 1'b0, 1'b0, 1'b0, P_U, 1'b1, 34'h011111000, 3'b100, 1'b0, 2'd1, 8'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0, req_priv = '0, req_mpp = '0;
    logic        req_sum = 1'b0, req_mxr = 1'b0, req_mprv = 1'b0;
    logic        xlat_mode = 1'b0;
    logic [21:0] xlat_root = 22'd1;
    logic        mem_valid, mem_write;
    logic        mem_ready = 1'b0, mem_err = 1'b0;
    logic [33:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid, resp_r, resp_w, resp_x, resp_fault;
    logic [33:0] resp_paddr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stall_cfg = 0;
    int stall_cnt = 0;
    int wr_n = 0;
    int rd_n = 0;
    logic [33:0] rd_log [4];
    logic [31:0] mem [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    sv32_walker u_sv32_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_priv(req_priv), .req_sum(req_sum), .req_mxr(req_mxr),
        .req_mprv(req_mprv), .req_mpp(req_mpp), .xlat_mode(xlat_mode), .xlat_root(xlat_root),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_r(resp_r), .resp_w(resp_w),
        .resp_x(resp_x), .resp_fault(resp_fault)
    );

    function automatic logic [8:0] widx(input logic [33:0] a);
        return {a[12], a[9:2]};
    endfunction

    // memory model: decides ready on falling edges, completes on the next rising edge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            stall_cnt = stall_cfg;
        end
        if (mem_valid) begin
            if (stall_cnt == 0) begin
                mem_ready = 1'b1;
                mem_err   = (mem_addr == ERR_ADDR);
                mem_rdata = mem[widx(mem_addr)];
                if (mem_write) begin
                    mem[widx(mem_addr)] = mem_wdata;
                    wr_n++;
                end else if (rd_n < 4) begin
                    rd_log[rd_n] = mem_addr;
                    rd_n++;
                end else begin
                    rd_n++;
                end
            end else begin
                stall_cnt--;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog expired: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic walk(input vec_t v, output int cycles, output int writes);
        int w0;
        @(negedge clk);
        w0 = wr_n;
        req_vaddr = v.va; req_kind = v.kind; req_priv = v.priv;
        req_sum = v.sum; req_mxr = v.mxr; req_mprv = v.mprv; req_mpp = v.mpp;
        xlat_mode = v.mode;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 1;
        while (!resp_valid && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
        writes = wr_n - w0;
    endtask

    task automatic run_vec(input vec_t v, input int n);
        int cycles, writes;
        string tag;
        walk(v, cycles, writes);
        tag = $sformatf("R%0d vec%0d", v.rq, n);
        chk({tag, " resp_valid"}, 64'(resp_valid), 64'd1);
        chk({tag, " fault"}, 64'(resp_fault), 64'(v.flt));
        chk({tag, " paddr"}, 64'(resp_paddr), 64'(v.pa));
        chk({tag, " rwx"}, 64'({resp_r, resp_w, resp_x}), 64'(v.rwx));
        chk({tag, " writes"}, 64'(writes), 64'(v.nwr));
    endtask

    initial begin
        int cycles, writes;
        vec_t v;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        // root table at page 1
        mem[widx(34'h1000)] = 32'h00000801;   // pointer to page 2
        mem[widx(34'h1004)] = 32'h123000CF;   // aligned superpage
        mem[widx(34'h1008)] = 32'h123014CF;   // misaligned superpage
        mem[widx(34'h100C)] = 32'h00000000;   // invalid
        // second-level table at page 2
        mem[widx(34'h2000)] = 32'h02AF34DF;   // user page, A and D set
        mem[widx(34'h2004)] = 32'h04444403;   // read-only, A clear
        mem[widx(34'h2008)] = 32'h08888847;   // read/write, D clear
        mem[widx(34'h200C)] = 32'h00000045;   // W only
        mem[widx(34'h2010)] = 32'h0000004D;   // W and X
        mem[widx(34'h2014)] = 32'h15555449;   // X only
        mem[widx(34'h2018)] = 32'h00001C01;   // pointer at last level
        mem[widx(34'h201C)] = 32'h00000000;   // invalid
        mem[widx(34'h2020)] = 32'h00000047;   // error response address

        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset req_ready", 64'(req_ready), 64'd1);
        chk("R12 reset resp_valid", 64'(resp_valid), 64'd0);
        chk("R12 reset mem_valid", 64'(mem_valid), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R1 latency of a bare translation
        v = VECS[0];
        walk(v, cycles, writes);
        chk("R1 bare latency", 64'(cycles), 64'd1);
        chk("R1 bare no memory access", 64'(writes), 64'd0);

        // R3 entry addresses
        rd_n = 0;
        v = VECS[4];
        walk(v, cycles, writes);
        chk("R3 superpage read count", 64'(rd_n), 64'd1);
        chk("R3 first-level address", 64'(rd_log[0]), 64'h1004);
        rd_n = 0;
        v = VECS[12];
        walk(v, cycles, writes);
        chk("R3 two-level read count", 64'(rd_n), 64'd2);
        chk("R3 root entry address", 64'(rd_log[0]), 64'h1000);
        chk("R3 leaf entry address", 64'(rd_log[1]), 64'h2008);
        chk("R11 write right after dirty set", 64'({resp_r, resp_w, resp_x}), 64'b110);

        // R9 written-back entries in memory
        chk("R9 accessed bit written", 64'(mem[widx(34'h2004)]), 64'h04444443);
        chk("R9 dirty bit written", 64'(mem[widx(34'h2008)]), 64'h088888C7);

        // R12 stalled memory: two reads with three stall cycles each
        stall_cfg = 3;
        stall_cnt = 3;
        v = VECS[12];
        walk(v, cycles, writes);
        chk("R12 stalled walk latency", 64'(cycles), 64'd9);
        chk("R12 stalled walk paddr", 64'(resp_paddr), 64'h022222010);
        chk("R12 stalled walk fault", 64'(resp_fault), 64'd0);
        stall_cfg = 0;
        stall_cnt = 0;
        v = VECS[12];
        walk(v, cycles, writes);
        chk("R12 unstalled walk latency", 64'(cycles), 64'd3);

        summary();
        $finish;
    end
endmodule